// File: doc/BRIEF.md
# Root Hub Port Status and Control Register

This block is the per-port status and control word of a single-port USB host root hub. Its low half reports the live state of the port: attachment, enable, suspend, reset in progress, power and device speed. Its high half holds sticky change flags that software acknowledges. Most bit positions carry one meaning on read and a different one on write. A write of 1 requests an action and a write of 0 is ignored, so software never has to read, modify and write the word.

Attachment and speed come in on two detect inputs, which are registered once. A write that asks for a port reset starts reset signalling on `port_reset_o`. A timer counts `tick` pulses (one per millisecond, so ten pulses make the 10 ms reset) and ends the reset on its own. A request to reset, enable or suspend a port with nothing attached is refused, and the connect-change flag is raised instead. This tells software to look at the port again. While `xfer_busy` reports a bus transaction in flight, writes are parked in a single slot and carried out once the transaction ends. `change_irq` follows the change flags and feeds the root hub interrupt.

Top module: `rh_port_ctrl`

## Requirements
- R1: Read bit 0 gives the attach state as registered one clock after `dev_present`. A write with bit 0 set clears the enable flag (read bit 1), and no write ever alters read bit 0.
- R2: A write with bit 4 set while attached drives `port_reset_o` high and read bit 4 to 1 from the next clock. A write with bit 4 set during an active reset neither restarts nor stretches the reset.
- R3: While detached, a write with bit 1, bit 2 or bit 4 set leaves enable, suspend and reset unchanged, and sets the connect-change flag (read bit 16).
- R4: Read bit 9 reports a low-speed device only while attached and reads 0 while detached. A write with bit 8 set sets the power flag (read bit 8), and a write with bit 9 set clears it. If both are set in one write, the clear wins.
- R5: The connect-change flag (bit 16) sets on every attach and every detach edge. A write with bit 16 set clears it, and a set in the same cycle wins over the clear.
- R6: Reset signalling lasts RESET_TICKS `tick` pulses. On the clock that takes the last pulse, read bit 4 and `port_reset_o` fall, the reset-change flag (bit 20) sets and the enable flag sets. A write with bit 20 set clears bit 20.
- R7: A write that arrives while `xfer_busy` is high has no effect while `xfer_busy` stays high. It takes effect on the first clock where `xfer_busy` is low.
- R8: Only one parked write is kept. A later write during the same busy period replaces the earlier one, and the earlier one never takes effect.
- R9: A write whose only set bits are unused or 0 leaves the whole read word unchanged.
- R10: `change_irq` is high exactly when read bit 16 or read bit 20 is 1.
- R11: A detach edge clears enable and suspend and aborts an active reset without setting bit 20.
- R12: A write with bit 2 set while attached sets suspend (read bit 2). A write with bit 3 set clears suspend, and starting a reset also clears it.
- R13: A synchronous `rst` clears every flag, any parked write and the timer, so the read word, `port_reset_o` and `change_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per millisecond, used by the reset timer |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 32 | Write-one action word |
| rd_data | output | 32 | Read view of status and change flags |
| dev_present | input | 1 | Device attach detect |
| dev_slow | input | 1 | Low-speed device detect |
| xfer_busy | input | 1 | A bus transaction is in progress |
| port_reset_o | output | 1 | Reset signalling active on the port |
| change_irq | output | 1 | Any change flag is set |

## Verification
The assertions check these rules on every cycle:
- nothing is applied while `xfer_busy` is high, and a busy-time write is the one held in the slot;
- a reset never begins on a detached port, and a refused request always raises bit 16;
- every attach change leaves bit 16 set, and bit 9 is 0 while detached;
- a detach always ends a reset and clears enable;
- the timer count stays within range, and a reset ends once the final tick arrives.

Only the bench scenarios can show the rest, using a behavioural model compared on every clock:
- the exact reset length in ticks;
- that a replaced parked write leaves no trace;
- that zero and unused bits are ignored;
- that an aborted reset never sets bit 20.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;

  localparam int REG_W = 32;

  // Bit positions shared by the read view and the write-one actions.
  localparam int B_CONN  = 0;   // read: attached        write: clear enable
  localparam int B_EN    = 1;   // read: enabled         write: set enable
  localparam int B_SUSP  = 2;   // read: suspended       write: set suspend
  localparam int B_RESUM = 3;   // read: 0               write: clear suspend
  localparam int B_RST   = 4;   // read: reset active    write: start reset
  localparam int B_PWR   = 8;   // read: powered         write: set power
  localparam int B_SLOW  = 9;   // read: low speed       write: clear power
  localparam int B_CSC   = 16;  // read: connect change  write: clear it
  localparam int B_RSC   = 20;  // read: reset change    write: clear it

  typedef struct packed {
    logic clr_en;
    logic set_en;
    logic set_susp;
    logic clr_susp;
    logic set_rst;
    logic set_pwr;
    logic clr_pwr;
    logic clr_csc;
    logic clr_rsc;
  } port_cmd_t;

  function automatic port_cmd_t decode_cmd(input logic [REG_W-1:0] w);
    port_cmd_t c;
    c.clr_en   = w[B_CONN];
    c.set_en   = w[B_EN];
    c.set_susp = w[B_SUSP];
    c.clr_susp = w[B_RESUM];
    c.set_rst  = w[B_RST];
    c.set_pwr  = w[B_PWR];
    c.clr_pwr  = w[B_SLOW];
    c.clr_csc  = w[B_CSC];
    c.clr_rsc  = w[B_RSC];
    return c;
  endfunction

endpackage

// File: rtl/rh_cmd_defer.sv
module rh_cmd_defer
  import rh_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cmd_valid,
  input  port_cmd_t cmd_in,
  input  logic      busy,
  output logic      apply_valid,
  output port_cmd_t apply_cmd
);

  logic      pend_v;
  port_cmd_t pend_c;

  // The held command goes first; a new command arriving then takes the slot.
  always_comb begin
    apply_valid = 1'b0;
    apply_cmd   = '0;
    if (!busy) begin
      if (pend_v) begin
        apply_valid = 1'b1;
        apply_cmd   = pend_c;
      end else if (cmd_valid) begin
        apply_valid = 1'b1;
        apply_cmd   = cmd_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v <= 1'b0;
      pend_c <= '0;
    end else if (cmd_valid && (busy || pend_v)) begin
      pend_v <= 1'b1;
      pend_c <= cmd_in;
    end else if (!busy) begin
      pend_v <= 1'b0;
    end
  end

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !apply_valid);

  // R8
  slot_replace_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> (pend_v && pend_c == $past(cmd_in)));

endmodule

// File: rtl/rh_reset_timer.sv
module rh_reset_timer #(
  parameter int RESET_TICKS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  input  logic abort,
  output logic active,
  output logic done
);

  localparam int CW = $clog2(RESET_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(RESET_TICKS - 1);

  logic [CW-1:0] cnt;

  assign done = active && tick && (cnt == LAST) && !abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (abort) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (active) begin
      if (tick) begin
        if (cnt == LAST) begin
          active <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  // R6
  end_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    (active && tick && cnt == LAST) |=> !active);

endmodule

// File: rtl/rh_attach_sync.sv
module rh_attach_sync (
  input  logic clk,
  input  logic rst,
  input  logic dev_present,
  input  logic dev_slow,
  output logic conn_q,
  output logic slow_q,
  output logic attach_edge,
  output logic detach_edge
);

  assign attach_edge = dev_present && !conn_q;
  assign detach_edge = !dev_present && conn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      conn_q <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      conn_q <= dev_present;
      slow_q <= dev_slow;
    end
  end

endmodule

// File: rtl/rh_port_ctrl.sv
module rh_port_ctrl
  import rh_port_pkg::*;
#(
  parameter int RESET_TICKS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             dev_present,
  input  logic             dev_slow,
  input  logic             xfer_busy,
  output logic             port_reset_o,
  output logic             change_irq
);

  port_cmd_t cmd_in, act;
  logic      act_v;
  logic      conn_q, slow_q, attach_edge, detach_edge;
  logic      rst_active, rst_done, rst_start;
  logic      en_q, susp_q, pwr_q, csc_q, rsc_q;
  logic      refused;
  logic      unused_bits;

  assign cmd_in = decode_cmd(wr_data);
  assign unused_bits = ^{wr_data[REG_W-1:B_RSC+1], wr_data[B_RSC-1:B_CSC+1],
                         wr_data[B_CSC-1:B_SLOW+1], wr_data[B_PWR-1:B_RST+1]};

  rh_cmd_defer u_defer (
    .clk(clk), .rst(rst), .cmd_valid(wr_en), .cmd_in(cmd_in),
    .busy(xfer_busy), .apply_valid(act_v), .apply_cmd(act)
  );

  rh_attach_sync u_attach (
    .clk(clk), .rst(rst), .dev_present(dev_present), .dev_slow(dev_slow),
    .conn_q(conn_q), .slow_q(slow_q),
    .attach_edge(attach_edge), .detach_edge(detach_edge)
  );

  assign rst_start = act_v && act.set_rst && conn_q;
  assign refused   = act_v && !conn_q && (act.set_en || act.set_susp || act.set_rst);

  rh_reset_timer #(.RESET_TICKS(RESET_TICKS)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .start(rst_start),
    .abort(detach_edge), .active(rst_active), .done(rst_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      susp_q <= 1'b0;
      pwr_q  <= 1'b0;
      csc_q  <= 1'b0;
      rsc_q  <= 1'b0;
    end else begin
      if (attach_edge || detach_edge || refused) csc_q <= 1'b1;
      else if (act_v && act.clr_csc)             csc_q <= 1'b0;

      if (rst_done)                   rsc_q <= 1'b1;
      else if (act_v && act.clr_rsc)  rsc_q <= 1'b0;

      if (detach_edge)                        en_q <= 1'b0;
      else if (rst_done)                      en_q <= 1'b1;
      else if (act_v && act.clr_en)           en_q <= 1'b0;
      else if (act_v && act.set_en && conn_q) en_q <= 1'b1;

      if (detach_edge || rst_start)             susp_q <= 1'b0;
      else if (act_v && act.clr_susp)           susp_q <= 1'b0;
      else if (act_v && act.set_susp && conn_q) susp_q <= 1'b1;

      if (act_v && act.clr_pwr)      pwr_q <= 1'b0;
      else if (act_v && act.set_pwr) pwr_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data         = '0;
    rd_data[B_CONN] = conn_q;
    rd_data[B_EN]   = en_q;
    rd_data[B_SUSP] = susp_q;
    rd_data[B_RST]  = rst_active;
    rd_data[B_PWR]  = pwr_q;
    rd_data[B_SLOW] = slow_q && conn_q;
    rd_data[B_CSC]  = csc_q;
    rd_data[B_RSC]  = rsc_q;
  end

  assign port_reset_o = rst_active;
  assign change_irq   = csc_q || rsc_q;

  // R2
  reset_needs_attach_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(port_reset_o) |-> $past(conn_q));

  // R3
  refused_flags_chk: assert property (@(posedge clk) disable iff (rst)
    refused |=> csc_q);

  // R5
  edge_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (attach_edge || detach_edge) |=> rd_data[B_CSC]);

  // R4
  slow_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_data[B_CONN] |-> !rd_data[B_SLOW]);

  // R11
  detach_abort_chk: assert property (@(posedge clk) disable iff (rst)
    detach_edge |=> (!port_reset_o && !rd_data[B_EN] && !rd_data[B_SUSP]));

endmodule

// File: tb/rh_port_ctrl_tb.sv
module rh_port_ctrl_tb;

  localparam int RT = 10;
  localparam int TICK_GAP = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        dev_present = 1'b0;
  logic        dev_slow = 1'b0;
  logic        xfer_busy = 1'b0;
  logic        port_reset_o;
  logic        change_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit tick_run = 1'b0;

  always #10 clk = ~clk;

  rh_port_ctrl #(.RESET_TICKS(RT)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .dev_present(dev_present), .dev_slow(dev_slow),
    .xfer_busy(xfer_busy), .port_reset_o(port_reset_o), .change_irq(change_irq)
  );

  // Behavioural reference model
  bit m_conn, m_slow, m_en, m_susp, m_pwr, m_rst, m_csc, m_rsc;
  int m_cnt;
  logic [31:0] parked[$];
  bit ap, fall, rise, fin, strt;
  logic [31:0] w;

  function automatic logic [31:0] model_word();
    logic [31:0] r = '0;
    r[0] = m_conn; r[1] = m_en; r[2] = m_susp; r[4] = m_rst;
    r[8] = m_pwr; r[9] = m_slow & m_conn; r[16] = m_csc; r[20] = m_rsc;
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_conn = 0; m_slow = 0; m_en = 0; m_susp = 0; m_pwr = 0;
      m_rst = 0; m_csc = 0; m_rsc = 0; m_cnt = 0;
      parked.delete();
    end else begin
      ap = 0; w = '0;
      if (xfer_busy) begin
        if (wr_en) begin parked.delete(); parked.push_back(wr_data); end
      end else if (parked.size() > 0) begin
        ap = 1; w = parked.pop_front();
        if (wr_en) parked.push_back(wr_data);
      end else if (wr_en) begin
        ap = 1; w = wr_data;
      end
      fall = m_conn && !dev_present;
      rise = !m_conn && dev_present;
      fin  = m_rst && tick && (m_cnt == RT - 1) && !fall;
      strt = ap && w[4] && m_conn;
      if (rise || fall || (ap && !m_conn && (w[1] || w[2] || w[4]))) m_csc = 1;
      else if (ap && w[16]) m_csc = 0;
      if (fin) m_rsc = 1; else if (ap && w[20]) m_rsc = 0;
      if (fall) m_en = 0; else if (fin) m_en = 1;
      else if (ap && w[0]) m_en = 0; else if (ap && w[1] && m_conn) m_en = 1;
      if (fall || strt) m_susp = 0; else if (ap && w[3]) m_susp = 0;
      else if (ap && w[2] && m_conn) m_susp = 1;
      if (ap && w[9]) m_pwr = 0; else if (ap && w[8]) m_pwr = 1;
      if (fall) begin m_rst = 0; m_cnt = 0; end
      else if (m_rst) begin
        if (tick) begin
          if (m_cnt == RT - 1) begin m_rst = 0; m_cnt = 0; end
          else m_cnt = m_cnt + 1;
        end
      end else if (strt) begin m_rst = 1; m_cnt = 0; end
      m_conn = dev_present;
      m_slow = dev_slow;
    end
  end

  // Every-clock comparison against the model (covers R1..R13 continuously)
  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (rd_data !== model_word() || port_reset_o !== m_rst ||
          change_irq !== (m_csc | m_rsc)) begin
        n_bad++;
        $display("FAIL MODEL rd=%h rst_o=%b irq=%b expected rd=%h rst_o=%b irq=%b",
                 rd_data, port_reset_o, change_irq, model_word(), m_rst, m_csc | m_rsc);
      end
    end
  end

  // Tick generator
  int tcount = 0;
  always @(negedge clk) begin
    tick <= 1'b0;
    if (tick_run) begin
      tcount <= tcount + 1;
      if (tcount % TICK_GAP == TICK_GAP - 1) tick <= 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 1'b0;
    chk("R13 reset word", rd_data, 32'h0);
    chk("R13 reset outputs", {30'd0, port_reset_o, change_irq}, 32'h0);

    // attach a full-speed device
    dev_present = 1'b1; idle(1);
    chk("R1 attach reads bit0", rd_data, 32'h0001_0001);
    chk("R10 irq on csc", {31'd0, change_irq}, 32'h1);
    wr(32'h0001_0000);
    chk("R5 csc cleared", rd_data, 32'h0000_0001);
    chk("R10 irq low", {31'd0, change_irq}, 32'h0);
    wr(32'hFF0E_7CE0);  // only unused bits
    chk("R9 unused bits ignored", rd_data, 32'h0000_0001);
    wr(32'h0);
    chk("R9 zero write ignored", rd_data, 32'h0000_0001);

    // power and speed
    wr(32'h0000_0100);
    chk("R4 power set", rd_data, 32'h0000_0101);
    dev_slow = 1'b1; idle(1);
    chk("R4 low speed visible", rd_data, 32'h0000_0301);
    wr(32'h0000_0300);
    chk("R4 clear power wins", rd_data & 32'h100, 32'h0);
    wr(32'h0000_0100);

    // enable, suspend
    wr(32'h0000_0002);
    chk("R1 enable set", rd_data & 32'h7, 32'h3);
    wr(32'h0000_0004);
    chk("R12 suspend set", rd_data & 32'h7, 32'h7);
    wr(32'h0000_0008);
    chk("R12 suspend clear", rd_data & 32'h7, 32'h3);
    wr(32'h0000_0001);
    chk("R1 clear enable keeps attach", rd_data & 32'h7, 32'h1);

    // port reset
    wr(32'h0000_0004);
    tick_run = 1'b1;
    wr(32'h0000_0010);
    chk("R2 reset active", {31'd0, port_reset_o}, 32'h1);
    chk("R12 reset clears suspend", rd_data & 32'h14, 32'h10);
    wait (u_dut.tick == 1'b0);
    repeat (RT - 1) begin @(posedge tick); end
    @(negedge clk);
    wr(32'h0000_0010);
    chk("R2 still active before last tick", {31'd0, port_reset_o}, 32'h1);
    @(posedge tick); @(negedge clk);
    chk("R6 reset ended", rd_data & 32'h0010_0013, 32'h0010_0003);
    chk("R10 irq on rsc", {31'd0, change_irq}, 32'h1);
    wr(32'h0010_0000);
    chk("R6 rsc cleared", rd_data & 32'h0010_0000, 32'h0);

    // detach during reset
    wr(32'h0000_0010);
    idle(12);
    dev_present = 1'b0; idle(1);
    chk("R11 detach aborts reset", rd_data & 32'h0011_0017, 32'h0001_0000);
    repeat (RT + 2) @(posedge tick);
    @(negedge clk);
    chk("R11 no rsc after abort", rd_data & 32'h0010_0000, 32'h0);
    chk("R4 slow hidden while detached", rd_data & 32'h200, 32'h0);
    wr(32'h0001_0000);
    wr(32'h0000_0016);
    chk("R3 refused requests", rd_data & 32'h0001_0017, 32'h0001_0000);
    wr(32'h0001_0000);

    // deferred writes
    dev_present = 1'b1; dev_slow = 1'b0; idle(1);
    wr(32'h0001_0000);
    @(negedge clk); xfer_busy = 1'b1;
    wr(32'h0000_0002);
    chk("R7 held while busy", rd_data & 32'h7, 32'h1);
    wr(32'h0000_0004);
    idle(3);
    chk("R8 still held", rd_data & 32'h7, 32'h1);
    xfer_busy = 1'b0; idle(1);
    chk("R8 latest write applied", rd_data & 32'h7, 32'h5);
    idle(4);
    chk("R8 earlier write dropped", rd_data & 32'h7, 32'h5);

    tick_run = 1'b0;
    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule